// File: doc/BRIEF.md
# Write-Back Word Cache Controller

The block is a small cache for single data words. It sits between a processor request port and a slower memory port. The processor issues fetch, load and store requests, one at a time. Each request carries an address, and a store also carries a data word. Each cache line holds the full request address as its tag, one data word, a valid bit, a dirty bit and an age counter.

A compile-time parameter chooses how lines are placed. In direct-mapped placement the low address bits select exactly one line. In fully associative placement every line is searched. When a line must be replaced, an empty line is used first; otherwise the least recently used line is evicted.

Stores are write-back with write-allocate. A store that misses takes over a line directly and never reads memory. A dirty line is written back to memory before its slot is reused. The processor side uses a request/ready handshake and receives a one-cycle done pulse with the read word. The memory side holds a request until the memory acknowledges it.

Top module: `wb_word_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready_o` is high, `cpu_done_o` is low and `mem_req_o` is low.
- R2: A fetch or load that hits returns the cached word with `cpu_done_o` and makes no memory transaction.
- R3: A fetch or load that misses makes one memory read at the exact request address. The returned word is delivered to the processor and stored in the chosen line as a clean line.
- R4: A store that hits replaces the line's word, marks the line dirty and makes no memory transaction.
- R5: A store that misses never reads memory. The chosen line takes the request address and store data, and it is marked dirty.
- R6: If the chosen victim is valid and dirty, its stored word is written to memory at its stored address. This write completes before any fill read starts.
- R7: A clean victim is overwritten without any memory write.
- R8: With `ASSOC`=0, the line index is the address ANDed with `LINES`-1. Two addresses that differ by a multiple of `LINES` evict each other.
- R9: With `ASSOC`=1, a request hits in any line whose tag equals the address. A miss fills the lowest-numbered invalid line before it evicts any valid line.
- R10: On every hit or fill, the touched line's age becomes 0. Every other valid line's age increases by one and stops at its maximum. With `ASSOC`=1, the victim among valid lines is the one with the greatest age, and a tie goes to the lowest index.
- R11: A request is accepted on a clock edge where both `cpu_req_i` and `cpu_ready_o` are high. `cpu_ready_o` stays low until the request completes. `cpu_done_o` is a single-cycle pulse. `mem_req_o` holds its address and direction until `mem_ack_i`.
- R12: The `cpu_op_i` encoding is 2'b00 fetch, 2'b01 load and 2'b10 store. Code 2'b11 behaves as a load, and fetch behaves exactly as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request |
| cpu_op_i | input | 2 | Operation code |
| cpu_addr_i | input | ADDR_W | Request address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | Controller can accept a request |
| cpu_done_o | output | 1 | Request complete, one-cycle pulse |
| cpu_rdata_o | output | DATA_W | Read word, valid with done |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_ack_i | input | 1 | Memory completes the transaction |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ack |

## Verification
The bench drives two addresses that share a direct-mapped index, with the first one left dirty. A design that skipped the write-back would lose the stored word, and the word read back later would then come from stale memory. A design that read before writing would show the wrong order in the memory model.

A store to an empty line checks that no memory read occurs; a design that allocated by reading first would add a transaction. In associative mode, sixteen addresses that would collide under direct mapping must all stay resident. A later sequence of hits makes a dirty line the oldest, so a design with a wrong age update or a wrong victim choice would evict a different line, or would write back the wrong address or data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } cache_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_RD
  } cache_st_e;
endpackage

// File: rtl/wbc_lookup.sv
module wbc_lookup #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16,
  parameter bit ASSOC  = 1'b0,
  localparam int IDX_W = $clog2(LINES),
  localparam int AGE_W = $clog2(LINES) + 1
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [LINES-1:0]              valid_i,
  input  logic [LINES-1:0][ADDR_W-1:0]  tags_i,
  input  logic [LINES-1:0][AGE_W-1:0]   ages_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              hit_idx_o,
  output logic [IDX_W-1:0]              vic_idx_o
);
  logic [IDX_W-1:0] dix;
  logic [IDX_W-1:0] a_vic;
  logic [AGE_W-1:0] best;
  logic             found_inv;

  assign dix = addr_i[IDX_W-1:0];

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = dix;
    if (ASSOC) begin
      for (int i = 0; i < LINES; i++)
        if (valid_i[i] && tags_i[i] == addr_i) begin
          hit_o     = 1'b1;
          hit_idx_o = IDX_W'(i);
        end
    end else begin
      hit_o = valid_i[dix] && (tags_i[dix] == addr_i);
    end
  end

  // empty line first, else oldest (lowest index wins ties)
  always_comb begin
    found_inv = 1'b0;
    a_vic     = '0;
    best      = ages_i[0];
    for (int i = 0; i < LINES; i++)
      if (!valid_i[i] && !found_inv) begin
        found_inv = 1'b1;
        a_vic     = IDX_W'(i);
      end
    if (!found_inv)
      for (int i = 1; i < LINES; i++)
        if (ages_i[i] > best) begin
          best  = ages_i[i];
          a_vic = IDX_W'(i);
        end
    vic_idx_o = ASSOC ? a_vic : dix;
  end
endmodule

// File: rtl/wbc_lines.sv
module wbc_lines #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int AGE_W = $clog2(LINES) + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [ADDR_W-1:0]             wr_tag_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          wr_dirty_i,
  output logic [LINES-1:0]              valid_o,
  output logic [LINES-1:0]              dirty_o,
  output logic [LINES-1:0][ADDR_W-1:0]  tags_o,
  output logic [LINES-1:0][DATA_W-1:0]  data_o,
  output logic [LINES-1:0][AGE_W-1:0]   ages_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      dirty_o <= '0;
      tags_o  <= '0;
      data_o  <= '0;
      ages_o  <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == wr_idx_i) begin
          valid_o[i] <= 1'b1;
          dirty_o[i] <= wr_dirty_i;
          tags_o[i]  <= wr_tag_i;
          data_o[i]  <= wr_data_i;
          ages_o[i]  <= '0;
        end else if (valid_o[i] && ages_o[i] != '1) begin
          ages_o[i] <= ages_o[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wb_word_cache.sv
module wb_word_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LINES  = 16,
  parameter bit ASSOC  = 1'b0,
  localparam int IDX_W = $clog2(LINES),
  localparam int AGE_W = $clog2(LINES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  cache_st_e         st_q, st_d;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [IDX_W-1:0]  vic_q;
  logic              done_q, done_d, is_store;

  logic [LINES-1:0]             valid, dirty;
  logic [LINES-1:0][ADDR_W-1:0] tags;
  logic [LINES-1:0][DATA_W-1:0] data;
  logic [LINES-1:0][AGE_W-1:0]  ages;
  logic                         hit;
  logic [IDX_W-1:0]             hit_idx, vic_idx;

  logic              wr_en, wr_dirty;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  assign is_store = (op_q == OP_STORE);

  wbc_lookup #(.ADDR_W(ADDR_W), .LINES(LINES), .ASSOC(ASSOC)) lookup_i (
    .addr_i   (addr_q),
    .valid_i  (valid),
    .tags_i   (tags),
    .ages_i   (ages),
    .hit_o    (hit),
    .hit_idx_o(hit_idx),
    .vic_idx_o(vic_idx)
  );

  wbc_lines #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) lines_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_tag_i  (addr_q),
    .wr_data_i (wr_data),
    .wr_dirty_i(wr_dirty),
    .valid_o   (valid),
    .dirty_o   (dirty),
    .tags_o    (tags),
    .data_o    (data),
    .ages_o    (ages)
  );

  always_comb begin
    st_d     = st_q;
    wr_en    = 1'b0;
    wr_idx   = vic_q;
    wr_data  = wdata_q;
    wr_dirty = 1'b1;
    done_d   = 1'b0;
    rdata_d  = wdata_q;
    unique case (st_q)
      ST_IDLE: if (cpu_req_i) st_d = ST_LOOK;
      ST_LOOK: begin
        if (hit) begin
          wr_en    = 1'b1;
          wr_idx   = hit_idx;
          wr_data  = is_store ? wdata_q : data[hit_idx];
          wr_dirty = is_store | dirty[hit_idx];
          rdata_d  = wr_data;
          done_d   = 1'b1;
          st_d     = ST_IDLE;
        end else if (valid[vic_idx] && dirty[vic_idx]) begin
          st_d = ST_WB;
        end else if (is_store) begin
          wr_en  = 1'b1;
          wr_idx = vic_idx;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_WB: if (mem_ack_i) begin
        if (is_store) begin
          wr_en  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_RD: if (mem_ack_i) begin
        wr_en    = 1'b1;
        wr_data  = mem_rdata_i;
        wr_dirty = 1'b0;
        rdata_d  = mem_rdata_i;
        done_d   = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      vic_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (done_d) rdata_q <= rdata_d;
      if (st_q == ST_IDLE && cpu_req_i) begin
        op_q    <= cpu_op_i;
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
      end
      if (st_q == ST_LOOK) vic_q <= vic_idx;
    end
  end

  assign cpu_ready_o = (st_q == ST_IDLE);
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
  assign mem_req_o   = (st_q == ST_WB) || (st_q == ST_RD);
  assign mem_we_o    = (st_q == ST_WB);
  assign mem_addr_o  = (st_q == ST_WB) ? tags[vic_q] : addr_q;
  assign mem_wdata_o = data[vic_q];
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16,
  parameter bit ASSOC  = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ready_o,
  input logic              cpu_done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic [1:0]        op_q,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(LINES - 1);

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cpu_ready_o); // R11
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o |=> !cpu_ready_o); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o); // R11
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
  AST_STORE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> op_q != OP_STORE); // R5
  AST_FILL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o == addr_q); // R3
  AST_DIRECT_WB_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !ASSOC |-> (mem_addr_o & MASK) == (addr_q & MASK)); // R8
endmodule

bind wb_word_cache wbc_checker #(.ADDR_W(ADDR_W), .LINES(LINES), .ASSOC(ASSOC)) chk_i (.*);

// File: tb/wbc_mem_model.sv
`timescale 1ns/1ps
module wbc_mem_model #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [2**ADDR_W];
  int rd_cnt = 0, wr_cnt = 0, seq = 0, wr_seq = 0, rd_seq = 0, wait_cnt = 0;
  logic [ADDR_W-1:0] last_waddr = '0;
  logic [DATA_W-1:0] last_wdata = '0;

  initial begin
    ack   = 1'b0;
    rdata = '0;
    for (int i = 0; i < 2**ADDR_W; i++) mem[i] = DATA_W'(16'h5A00 | i);
  end

  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
    end else if (req) begin
      wait_cnt++;
      if (wait_cnt == 2) begin
        wait_cnt = 0;
        ack = 1'b1;
        seq++;
        if (we) begin
          mem[addr]  = wdata;
          last_waddr = addr;
          last_wdata = wdata;
          wr_cnt++;
          wr_seq = seq;
        end else begin
          rdata = mem[addr];
          rd_cnt++;
          rd_seq = seq;
        end
      end
    end
  end
endmodule

// File: tb/wb_word_cache_tb_top.sv
`timescale 1ns/1ps
module wb_word_cache_tb_top;
  import wbc_pkg::*;
  localparam int AW = 8, DW = 16, NL = 16;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic cpu_req = 1'b0;
  logic [1:0] cpu_op = 2'b00;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  logic rdy_d, done_d, mreq_d, mwe_d, ack_d, rdy_a, done_a, mreq_a, mwe_a, ack_a;
  logic [DW-1:0] rd_d, rd_a, mwd_d, mwd_a, mrd_d, mrd_a;
  logic [AW-1:0] ma_d, ma_a;

  wb_word_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .ASSOC(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req & ~sel), .cpu_op_i(cpu_op),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ready_o(rdy_d),
    .cpu_done_o(done_d), .cpu_rdata_o(rd_d), .mem_req_o(mreq_d), .mem_we_o(mwe_d),
    .mem_addr_o(ma_d), .mem_wdata_o(mwd_d), .mem_ack_i(ack_d), .mem_rdata_i(mrd_d));
  wbc_mem_model #(.ADDR_W(AW), .DATA_W(DW)) mem_d_i (
    .clk(clk), .req(mreq_d), .we(mwe_d), .addr(ma_d), .wdata(mwd_d), .ack(ack_d), .rdata(mrd_d));

  wb_word_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .ASSOC(1'b1)) dut_a_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req & sel), .cpu_op_i(cpu_op),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ready_o(rdy_a),
    .cpu_done_o(done_a), .cpu_rdata_o(rd_a), .mem_req_o(mreq_a), .mem_we_o(mwe_a),
    .mem_addr_o(ma_a), .mem_wdata_o(mwd_a), .mem_ack_i(ack_a), .mem_rdata_i(mrd_a));
  wbc_mem_model #(.ADDR_W(AW), .DATA_W(DW)) mem_a_i (
    .clk(clk), .req(mreq_a), .we(mwe_a), .addr(ma_a), .wdata(mwd_a), .ack(ack_a), .rdata(mrd_a));

  function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
    return DW'(16'h5A00 | a);
  endfunction
  function automatic int rds(); return sel ? mem_a_i.rd_cnt : mem_d_i.rd_cnt; endfunction
  function automatic int wrs(); return sel ? mem_a_i.wr_cnt : mem_d_i.wr_cnt; endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one request; returns read data and memory traffic it caused
  task automatic access(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int nrd, output int nwr);
    int r0, w0;
    r0 = rds(); w0 = wrs();
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R11 ready low while busy", sel ? rdy_a : rdy_d, 0);
    while (!(sel ? done_a : done_d)) @(negedge clk);
    rd = sel ? rd_a : rd_d;
    nrd = rds() - r0; nwr = wrs() - w0;
    @(negedge clk);
    check("R11 done single pulse", sel ? done_a : done_d, 0);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", rdy_d, 1);
    check("R1 done low after reset", done_d, 0);
    check("R1 no mem req after reset", mreq_d | mreq_a, 0);
  endtask

  task automatic t_direct();
    logic [DW-1:0] rd; int nr, nw;
    sel = 1'b0;
    access(OP_LOAD, 8'h05, '0, rd, nr, nw);
    check("R3 miss data", rd, init_val(8'h05)); check("R3 one read", nr, 1);
    access(OP_LOAD, 8'h05, '0, rd, nr, nw);
    check("R2 hit data", rd, init_val(8'h05)); check("R2 no read", nr, 0);
    access(OP_STORE, 8'h05, 16'hBEEF, rd, nr, nw);
    check("R4 store hit no traffic", nr + nw, 0);
    access(OP_LOAD, 8'h05, '0, rd, nr, nw);
    check("R4 store data kept", rd, 16'hBEEF); check("R4 no read", nr, 0);
    access(OP_LOAD, 8'h15, '0, rd, nr, nw);
    check("R8 collision data", rd, init_val(8'h15));
    check("R6 one write-back", nw, 1); check("R6 one read", nr, 1);
    check("R6 wb addr", mem_d_i.last_waddr, 8'h05);
    check("R6 wb data", mem_d_i.last_wdata, 16'hBEEF);
    check("R6 write before read", mem_d_i.wr_seq < mem_d_i.rd_seq, 1);
    access(OP_LOAD, 8'h05, '0, rd, nr, nw);
    check("R7 clean victim no write", nw, 0); check("R8 evicted re-read", nr, 1);
    check("R6 written-back word", rd, 16'hBEEF);
    access(OP_STORE, 8'h27, 16'h1234, rd, nr, nw);
    check("R5 store miss no traffic", nr + nw, 0);
    access(OP_FETCH, 8'h27, '0, rd, nr, nw);
    check("R5 allocated data", rd, 16'h1234); check("R12 fetch hit no read", nr, 0);
    access(2'b11, 8'h48, '0, rd, nr, nw);
    check("R12 code 11 as load", rd, init_val(8'h48)); check("R12 code 11 read", nr, 1);
  endtask

  task automatic t_assoc();
    logic [DW-1:0] rd; int nr, nw, tot;
    sel = 1'b1;
    tot = 0;
    for (int k = 0; k < 16; k++) begin
      access(OP_LOAD, AW'(k * 16), '0, rd, nr, nw);
      tot += nr;
      check("R9 fill data", rd, init_val(AW'(k * 16)));
    end
    check("R9 sixteen fills", tot, 16);
    tot = 0;
    for (int k = 0; k < 16; k++) begin
      access(OP_LOAD, AW'(k * 16), '0, rd, nr, nw);
      tot += nr + nw;
    end
    check("R9 colliding set all resident", tot, 0);
    access(OP_STORE, 8'h10, 16'h1111, rd, nr, nw);
    access(OP_LOAD, 8'h03, '0, rd, nr, nw);
    check("R10 clean LRU evicted no write", nw, 0);
    access(OP_LOAD, 8'h10, '0, rd, nr, nw);
    check("R10 young line kept", nr, 0); check("R4 assoc store data", rd, 16'h1111);
    access(OP_LOAD, 8'h00, '0, rd, nr, nw);
    check("R10 oldest was evicted", nr, 1);
    access(OP_STORE, 8'h30, 16'hCAFE, rd, nr, nw);
    tot = 0;
    for (int k = 4; k < 16; k++) begin
      access(OP_LOAD, AW'(k * 16), '0, rd, nr, nw);
      tot += nr;
    end
    access(OP_LOAD, 8'h03, '0, rd, nr, nw); tot += nr;
    access(OP_LOAD, 8'h10, '0, rd, nr, nw); tot += nr;
    access(OP_LOAD, 8'h00, '0, rd, nr, nw); tot += nr;
    check("R10 touch hits", tot, 0);
    access(OP_LOAD, 8'h05, '0, rd, nr, nw);
    check("R10 dirty oldest written back", nw, 1);
    check("R6 assoc wb addr", mem_a_i.last_waddr, 8'h30);
    check("R6 assoc wb data", mem_a_i.last_wdata, 16'hCAFE);
    access(OP_LOAD, 8'h30, '0, rd, nr, nw);
    check("R10 evicted line re-read", nr, 1); check("R6 data survives", rd, 16'hCAFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_assoc();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule